// File: doc/BRIEF.md
# PC Card Memory Host Controller

This block sits on the host side of a 16-bit memory card slot. Each request carries a 26-bit address, a space bit that picks common or attribute memory, a two-bit byte-lane mask and, for writes, a data word. The controller converts the request into a strobed card access. It drives the two active-low card enables from the lane mask and the register-select pin from the space bit. It then pulses the read or write strobe and extends that strobe for as long as the card holds its wait line low. Each access ends with a one-cycle response pulse. For a read, the pulse carries the captured data.

The card-detect, battery-voltage and ready pins from the slot are resynchronised and decoded. The decode gives a card-present flag, a misinsertion flag and a three-level battery code. It also gives a one-cycle event whenever the present state changes. A request that arrives with no card properly seated is refused at once. A request that arrives while the card reports busy is held until the card becomes ready.

Top module: `cardmem_host`

## Requirements
- R1: While reset is high, both card enables, both strobes and register-select are high, the data drive enable is low, and busy, card_present, status_change, req_accept, req_reject and rsp_valid are all low.
- R2: Lane mask bit 0 selects the low byte (D7..D0) and drives card_ce1_n low. Bit 1 selects the high byte (D15..D8) and drives card_ce2_n low. Mask 2'b00 leaves both enables high and raises neither strobe. The enables stay constant from the setup cycle through the hold cycle and return high in the response cycle.
- R3: req_attr=1 drives card_reg_n low (attribute space) and req_attr=0 drives it high (common space) for the whole access. card_reg_n is high when no access is running.
- R4: A read lowers only card_oe_n. A write lowers only card_we_n and raises card_d_oe from the setup cycle through the hold cycle. During a write, card_d_out carries the write data on the selected lanes and zero on the unselected lanes.
- R5: An accepted access runs as follows. There is one setup cycle with address and enables valid and both strobes high. The strobe is then low for max(strobe_cycles,1) cycles plus any wait extension. One hold cycle follows with the strobe high and the enables still low. rsp_valid is high for exactly one cycle right after the hold cycle.
- R6: card_wait_n is sampled at the end of each strobe cycle, starting with the last minimum cycle. Each cycle it is sampled low adds one strobe cycle. Its value during the earlier minimum cycles has no effect.
- R7: Read data is captured at the end of the last strobe cycle. Selected lanes keep their bit positions, and unselected lanes and all write responses return zero on rsp_rdata.
- R8: After a two-flop synchroniser, card-detect pins both low give card_present=1. Pins that differ give card_misinserted=1. Pins both high give neither flag.
- R9: status_change pulses for one cycle each time card_present changes, and stays low while card_present is unchanged.
- R10: batt_state is 2'b00 when both battery pins are high (good). It is 2'b01 when bvd2=0 and bvd1=1 (replace soon). It is 2'b10 when bvd1=0 (data may be lost).
- R11: A request made while card_present is low gets a one-cycle req_reject pulse, no req_accept and no strobe.
- R12: While the synchronised ready pin is low, a pending request is neither accepted nor rejected. It is accepted after ready returns high.
- R13: Requests are accepted only while idle. busy is high from the setup cycle through the hold cycle and low in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending; hold until accepted or rejected |
| req_write | input | 1 | 1 = write, 0 = read |
| req_attr | input | 1 | 1 = attribute space, 0 = common space |
| req_addr | input | 26 | Card byte address |
| req_lanes | input | 2 | Byte lanes: bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| strobe_cycles | input | 4 | Minimum strobe width in cycles (0 acts as 1) |
| req_accept | output | 1 | One-cycle pulse: request taken |
| req_reject | output | 1 | One-cycle pulse: request refused, no card |
| rsp_valid | output | 1 | One-cycle pulse: access complete |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| busy | output | 1 | Access in progress |
| card_a | output | 26 | Card address |
| card_ce1_n | output | 1 | Low-byte card enable, active low |
| card_ce2_n | output | 1 | High-byte card enable, active low |
| card_oe_n | output | 1 | Read strobe, active low |
| card_we_n | output | 1 | Write strobe, active low |
| card_reg_n | output | 1 | Low selects attribute space |
| card_d_out | output | 16 | Data driven to card |
| card_d_oe | output | 1 | Drive enable for card_d_out |
| card_d_in | input | 16 | Data from card |
| card_wait_n | input | 1 | Card wait, low extends strobe |
| card_ready | input | 1 | Card ready, low means busy |
| card_cd1_n | input | 1 | Card detect pin 1 |
| card_cd2_n | input | 1 | Card detect pin 2 |
| card_bvd1 | input | 1 | Battery voltage pin 1 |
| card_bvd2 | input | 1 | Battery voltage pin 2 |
| card_present | output | 1 | Card properly seated |
| card_misinserted | output | 1 | Card seated crookedly |
| batt_state | output | 2 | Battery code: 0 good, 1 warn, 2 fail |
| status_change | output | 1 | One-cycle pulse on presence change |

## Verification
Accesses are driven with random address, space, lane mask, minimum width from 0 to 15 and wait extensions from 0 to 3, together with directed cases. The directed cases are the empty lane mask, a zero width, the widest width and a long wait under a one-cycle minimum. Together these separate an error in the width count from an error in wait sampling, and a wrong enable mapping from wrong read or write data steering. During the minimum cycles the bench holds wait low. Because that wait must have no effect, a controller that samples wait too early shows a wrong strobe length. The detect pins are stepped through seated, crooked, empty and seated again. The pulse count in each window shows whether the event fires only on a real presence change. The access held off by a busy card and the access refused with no card show that the two conditions are told apart.

// File: rtl/cardmem_pkg.sv
package cardmem_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_STROBE = 2'd2,
    SQ_HOLD   = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    BATT_GOOD = 2'd0,
    BATT_WARN = 2'd1,
    BATT_FAIL = 2'd2
  } batt_t;

endpackage

// File: rtl/cardmem_lanes.sv
// Byte-lane steering: keeps the bytes of selected lanes in place and zeroes the others.
module cardmem_lanes #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic [LANES-1:0]  lane_sel,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_out[g*LANE_W +: LANE_W] = lane_sel[g] ? data_in[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/cardmem_status.sv
// Slot status: resynchronises the detect, battery and ready pins and decodes them.
module cardmem_status
  import cardmem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cd1_n,
  input  logic       cd2_n,
  input  logic       bvd1,
  input  logic       bvd2,
  input  logic       ready_raw,
  output logic       present,
  output logic       misinserted,
  output logic [1:0] batt_state,
  output logic       ready_ok,
  output logic       status_change
);

  localparam int SW = 5;
  // bit order {ready, bvd2, bvd1, cd2_n, cd1_n}; reset value means empty slot, not ready
  localparam logic [SW-1:0] SYNC_RST = 5'b01111;

  logic [SW-1:0] raw;
  logic [SW-1:0] stage_q [SYNC_STAGES];
  logic [SW-1:0] pins_s;
  logic          present_d;
  logic          present_q, mis_q, ready_q, change_q;
  logic [1:0]    batt_q;

  assign raw = {ready_raw, bvd2, bvd1, cd2_n, cd1_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= SYNC_RST;
    end else begin
      stage_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign pins_s    = stage_q[SYNC_STAGES-1];
  assign present_d = (pins_s[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q <= 1'b0;
      mis_q     <= 1'b0;
      ready_q   <= 1'b0;
      change_q  <= 1'b0;
      batt_q    <= BATT_GOOD;
    end else begin
      present_q <= present_d;
      change_q  <= (present_d != present_q);
      mis_q     <= pins_s[0] ^ pins_s[1];
      ready_q   <= pins_s[4];
      case (pins_s[3:2])
        2'b11:   batt_q <= BATT_GOOD;
        2'b01:   batt_q <= BATT_WARN;
        default: batt_q <= BATT_FAIL;
      endcase
    end
  end

  assign present       = present_q;
  assign misinserted   = mis_q;
  assign ready_ok      = ready_q;
  assign status_change = change_q;
  assign batt_state    = batt_q;

  AST_PRESENT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(present_q && mis_q)); // R8
  AST_CHANGE_TRACKS: assert property (@(posedge clk) disable iff (rst)
    change_q |-> (present_q != $past(present_q))); // R9
  AST_BATT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    batt_q != 2'b11); // R10

endmodule

// File: rtl/cardmem_seq.sv
// Access sequencer: setup, strobe (minimum plus wait), hold, response.
module cardmem_seq
  import cardmem_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int LANES  = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_attr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_lanes,
  input  logic [DATA_W-1:0] wdata_st,
  input  logic [CNT_W-1:0]  strobe_cycles,
  input  logic              present,
  input  logic              ready_ok,
  input  logic              wait_n,
  input  logic [DATA_W-1:0] rdata_st,
  output logic              req_accept,
  output logic              req_reject,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] card_a,
  output logic [LANES-1:0]  ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              reg_n,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe
);

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              write_q;
  logic              accept_q, reject_q, rsp_q;
  logic [DATA_W-1:0] rdata_q, dout_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  ce_n_q;
  logic              oe_n_q, we_n_q, reg_n_q, doe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      write_q  <= 1'b0;
      accept_q <= 1'b0;
      reject_q <= 1'b0;
      rsp_q    <= 1'b0;
      rdata_q  <= '0;
      dout_q   <= '0;
      addr_q   <= '0;
      ce_n_q   <= '1;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      reg_n_q  <= 1'b1;
      doe_q    <= 1'b0;
    end else begin
      accept_q <= 1'b0;
      reject_q <= 1'b0;
      rsp_q    <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (req_valid) begin
            if (!present) begin
              reject_q <= 1'b1;
            end else if (ready_ok) begin
              accept_q <= 1'b1;
              addr_q   <= req_addr;
              ce_n_q   <= ~req_lanes;
              reg_n_q  <= ~req_attr;
              write_q  <= req_write;
              dout_q   <= req_write ? wdata_st : '0;
              doe_q    <= req_write;
              cnt_q    <= (strobe_cycles == '0) ? '0 : strobe_cycles - CNT_W'(1);
              state_q  <= SQ_SETUP;
            end
          end
        end
        SQ_SETUP: begin
          state_q <= SQ_STROBE;
          if (ce_n_q != '1) begin
            if (write_q) we_n_q <= 1'b0;
            else         oe_n_q <= 1'b0;
          end
        end
        SQ_STROBE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (wait_n) begin
            state_q <= SQ_HOLD;
            oe_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            rdata_q <= write_q ? '0 : rdata_st;
          end
        end
        default: begin
          state_q <= SQ_IDLE;
          ce_n_q  <= '1;
          reg_n_q <= 1'b1;
          doe_q   <= 1'b0;
          dout_q  <= '0;
          rsp_q   <= 1'b1;
        end
      endcase
    end
  end

  assign req_accept = accept_q;
  assign req_reject = reject_q;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
  assign busy       = (state_q != SQ_IDLE);
  assign card_a     = addr_q;
  assign ce_n       = ce_n_q;
  assign oe_n       = oe_n_q;
  assign we_n       = we_n_q;
  assign reg_n      = reg_n_q;
  assign d_out      = dout_q;
  assign d_oe       = doe_q;

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n_q && !we_n_q)); // R4
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !oe_n_q |-> !doe_q); // R4
  AST_STROBE_HAS_CE: assert property (@(posedge clk) disable iff (rst)
    (!oe_n_q || !we_n_q) |-> (ce_n_q != '1)); // R2
  AST_CE_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!oe_n_q || !we_n_q) |-> $stable(ce_n_q)); // R2
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($fell(oe_n_q) || $fell(we_n_q)) |-> ($past(ce_n_q) != '1)); // R5
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($rose(oe_n_q) || $rose(we_n_q)) |-> $past(wait_n)); // R6
  AST_REJECT_EXCL: assert property (@(posedge clk) disable iff (rst)
    req_reject |-> !req_accept); // R11
  AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_accept |=> !req_accept); // R13

endmodule

// File: rtl/cardmem_host.sv
// Host controller for a 16-bit memory card slot.
module cardmem_host #(
  parameter int ADDR_W      = 26,
  parameter int LANE_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_attr,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_lanes,
  input  logic [2*LANE_W-1:0]  req_wdata,
  input  logic [CNT_W-1:0]     strobe_cycles,
  output logic                 req_accept,
  output logic                 req_reject,
  output logic                 rsp_valid,
  output logic [2*LANE_W-1:0]  rsp_rdata,
  output logic                 busy,
  output logic [ADDR_W-1:0]    card_a,
  output logic                 card_ce1_n,
  output logic                 card_ce2_n,
  output logic                 card_oe_n,
  output logic                 card_we_n,
  output logic                 card_reg_n,
  output logic [2*LANE_W-1:0]  card_d_out,
  output logic                 card_d_oe,
  input  logic [2*LANE_W-1:0]  card_d_in,
  input  logic                 card_wait_n,
  input  logic                 card_ready,
  input  logic                 card_cd1_n,
  input  logic                 card_cd2_n,
  input  logic                 card_bvd1,
  input  logic                 card_bvd2,
  output logic                 card_present,
  output logic                 card_misinserted,
  output logic [1:0]           batt_state,
  output logic                 status_change
);

  // two card enables fix the lane count
  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] wdata_st, rdata_st;
  logic [LANES-1:0]  ce_n;
  logic              present, ready_ok;

  cardmem_status #(.SYNC_STAGES(SYNC_STAGES)) i_status (
    .clk          (clk),
    .rst          (rst),
    .cd1_n        (card_cd1_n),
    .cd2_n        (card_cd2_n),
    .bvd1         (card_bvd1),
    .bvd2         (card_bvd2),
    .ready_raw    (card_ready),
    .present      (present),
    .misinserted  (card_misinserted),
    .batt_state   (batt_state),
    .ready_ok     (ready_ok),
    .status_change(status_change)
  );

  cardmem_lanes #(.LANE_W(LANE_W), .LANES(LANES)) i_lanes_wr (
    .lane_sel(req_lanes),
    .data_in (req_wdata),
    .data_out(wdata_st)
  );

  cardmem_lanes #(.LANE_W(LANE_W), .LANES(LANES)) i_lanes_rd (
    .lane_sel(~ce_n),
    .data_in (card_d_in),
    .data_out(rdata_st)
  );

  cardmem_seq #(
    .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) i_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_attr     (req_attr),
    .req_addr     (req_addr),
    .req_lanes    (req_lanes),
    .wdata_st     (wdata_st),
    .strobe_cycles(strobe_cycles),
    .present      (present),
    .ready_ok     (ready_ok),
    .wait_n       (card_wait_n),
    .rdata_st     (rdata_st),
    .req_accept   (req_accept),
    .req_reject   (req_reject),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .busy         (busy),
    .card_a       (card_a),
    .ce_n         (ce_n),
    .oe_n         (card_oe_n),
    .we_n         (card_we_n),
    .reg_n        (card_reg_n),
    .d_out        (card_d_out),
    .d_oe         (card_d_oe)
  );

  assign card_ce1_n   = ce_n[0];
  assign card_ce2_n   = ce_n[1];
  assign card_present = present;

endmodule

// File: tb/test_cardmem_host.sv
module test_cardmem_host;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_attr = 1'b0;
  logic [25:0] req_addr = '0;
  logic [1:0]  req_lanes = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  strobe_cycles = '0;
  logic        req_accept, req_reject, rsp_valid, busy;
  logic [15:0] rsp_rdata;
  logic [25:0] card_a;
  logic        card_ce1_n, card_ce2_n, card_oe_n, card_we_n, card_reg_n, card_d_oe;
  logic [15:0] card_d_out, card_d_in;
  logic        card_wait_n = 1'b1, card_ready = 1'b1;
  logic        card_cd1_n = 1'b0, card_cd2_n = 1'b0, card_bvd1 = 1'b1, card_bvd2 = 1'b1;
  logic        card_present, card_misinserted, status_change;
  logic [1:0]  batt_state;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  // card model: read data is a function of the address
  assign card_d_in = card_a[15:0] ^ 16'hA5C3;

  cardmem_host i_cardmem_host (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_attr(req_attr),
    .req_addr(req_addr), .req_lanes(req_lanes), .req_wdata(req_wdata),
    .strobe_cycles(strobe_cycles), .req_accept(req_accept), .req_reject(req_reject),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy), .card_a(card_a),
    .card_ce1_n(card_ce1_n), .card_ce2_n(card_ce2_n), .card_oe_n(card_oe_n),
    .card_we_n(card_we_n), .card_reg_n(card_reg_n), .card_d_out(card_d_out),
    .card_d_oe(card_d_oe), .card_d_in(card_d_in), .card_wait_n(card_wait_n),
    .card_ready(card_ready), .card_cd1_n(card_cd1_n), .card_cd2_n(card_cd2_n),
    .card_bvd1(card_bvd1), .card_bvd2(card_bvd2), .card_present(card_present),
    .card_misinserted(card_misinserted), .batt_state(batt_state),
    .status_change(status_change)
  );

  function automatic logic [15:0] lane_mask(logic [1:0] lanes, logic [15:0] d);
    return {lanes[1] ? d[15:8] : 8'h00, lanes[0] ? d[7:0] : 8'h00};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic count_changes(int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (status_change) cnt++;
    end
  endtask

  task automatic do_access(bit wr, bit attr, logic [25:0] addr, logic [1:0] lanes,
                           logic [15:0] wd, int n, int w);
    int nmin = (n == 0) ? 1 : n;
    int exp_low = (lanes == 2'b00) ? 0 : nmin + w;
    int low = 0, hold = 0, guard = 0;
    bit ok_ce = 1, ok_kind = 1, ok_data = 1, ok_busy = 1, ok_reg = 1;
    logic [15:0] exp_rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_attr = attr; req_addr = addr;
    req_lanes = lanes; req_wdata = wd; strobe_cycles = 4'(n); card_wait_n = 1'b1;
    do begin
      @(negedge clk);
      guard++;
    end while (!req_accept && guard < 50);
    req_valid = 1'b0;
    chk(req_accept, "R13", "accept", 32'(req_accept), 1);
    // setup cycle
    chk(card_oe_n && card_we_n, "R5", "setup strobes high", {card_oe_n, card_we_n}, 2'b11);
    chk({card_ce2_n, card_ce1_n} == ~lanes, "R2", "enables", {card_ce2_n, card_ce1_n}, ~lanes);
    chk(card_reg_n == !attr, "R3", "reg select", 32'(card_reg_n), 32'(!attr));
    chk(card_a == addr, "R5", "address", card_a, addr);
    chk(card_d_oe == wr, "R4", "drive enable", 32'(card_d_oe), 32'(wr));
    if (wr) chk(card_d_out == lane_mask(lanes, wd), "R4", "write data", card_d_out, lane_mask(lanes, wd));
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (rsp_valid || guard > 60) break;
      if (!busy) ok_busy = 0;
      if (card_reg_n != !attr) ok_reg = 0;
      if ({card_ce2_n, card_ce1_n} != ~lanes) ok_ce = 0;
      if (card_d_oe != wr) ok_data = 0;
      if (!card_oe_n || !card_we_n) begin
        low++;
        if (wr ? !card_oe_n : !card_we_n) ok_kind = 0;
        if (hold != 0) ok_kind = 0;
        card_wait_n = (low >= nmin + w);
      end else if (low > 0) begin
        hold++;
      end
    end
    card_wait_n = 1'b1;
    exp_rd = wr ? 16'h0 : lane_mask(lanes, addr[15:0] ^ 16'hA5C3);
    chk(rsp_valid, "R5", "response pulse", 32'(rsp_valid), 1);
    chk(low == exp_low, (w > 0) ? "R6" : "R5", "strobe length", low, exp_low);
    if (lanes != 2'b00) chk(hold == 1, "R5", "hold cycles", hold, 1);
    chk(ok_ce, "R2", "enables steady", 32'(ok_ce), 1);
    chk(ok_kind, "R4", "strobe kind", 32'(ok_kind), 1);
    chk(ok_data, "R4", "drive window", 32'(ok_data), 1);
    chk(ok_reg, "R3", "reg steady", 32'(ok_reg), 1);
    chk(ok_busy, "R13", "busy during access", 32'(ok_busy), 1);
    chk(rsp_rdata == exp_rd, "R7", "read data", rsp_rdata, exp_rd);
    chk(card_ce1_n && card_ce2_n && card_reg_n && !card_d_oe, "R2", "released in response cycle",
        {card_ce2_n, card_ce1_n, card_reg_n, card_d_oe}, 4'b1110);
    chk(!busy, "R13", "idle at response", 32'(busy), 0);
    @(negedge clk);
    chk(!rsp_valid, "R5", "response one cycle", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: actual hung expected done");
    report();
  end

  initial begin
    int cnt;
    int unsigned dummy;
    dummy = $urandom(32'h5EED_C0DE);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(card_ce1_n && card_ce2_n && card_oe_n && card_we_n && card_reg_n && !card_d_oe,
        "R1", "pins in reset", {card_ce1_n, card_ce2_n, card_oe_n, card_we_n, card_reg_n, card_d_oe}, 6'b111110);
    chk(!busy && !card_present && !status_change && !req_accept && !req_reject && !rsp_valid,
        "R1", "flags in reset", {busy, card_present, status_change, req_accept, req_reject, rsp_valid}, 0);
    rst = 1'b0;

    // R8 R9 insertion seen after reset
    count_changes(8, cnt);
    chk(cnt == 1, "R9", "insert event", cnt, 1);
    chk(card_present && !card_misinserted, "R8", "seated", {card_present, card_misinserted}, 2'b10);
    count_changes(8, cnt);
    chk(cnt == 0, "R9", "no event when steady", cnt, 0);

    // directed accesses
    do_access(1'b0, 1'b0, 26'h0001234, 2'b11, 16'h0, 2, 0);
    do_access(1'b1, 1'b1, 26'h3FFFFFF, 2'b01, 16'hBEEF, 1, 0);
    do_access(1'b1, 1'b0, 26'h0000002, 2'b10, 16'hCAFE, 3, 2);
    do_access(1'b0, 1'b1, 26'h2AAAAAA, 2'b10, 16'h0, 0, 0);
    do_access(1'b0, 1'b0, 26'h0000100, 2'b01, 16'h0, 15, 0);
    do_access(1'b0, 1'b0, 26'h1555555, 2'b11, 16'h0, 1, 3);
    do_access(1'b1, 1'b0, 26'h0000040, 2'b00, 16'h1234, 2, 0);
    do_access(1'b0, 1'b1, 26'h0000041, 2'b00, 16'h0, 0, 0);

    // random accesses
    for (int k = 0; k < 40; k++) begin
      do_access(1'($urandom), 1'($urandom), 26'($urandom), 2'($urandom),
                16'($urandom), int'($urandom_range(0, 15)), int'($urandom_range(0, 3)));
    end

    // R12 busy card holds the request off
    card_ready = 1'b0;
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_lanes = 2'b11; req_addr = 26'h77; strobe_cycles = 4'd1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (req_accept || req_reject || busy) cnt++;
    end
    chk(cnt == 0, "R12", "held while not ready", cnt, 0);
    card_ready = 1'b1;
    cnt = 0;
    while (!req_accept && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    req_valid = 1'b0;
    chk(req_accept, "R12", "accepted once ready", 32'(req_accept), 1);
    while (!rsp_valid && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    chk(rsp_rdata == lane_mask(2'b11, 16'h77 ^ 16'hA5C3), "R7", "data after ready wait",
        rsp_rdata, lane_mask(2'b11, 16'h77 ^ 16'hA5C3));
    @(negedge clk);

    // R8 R9 crooked card
    card_cd2_n = 1'b1;
    count_changes(8, cnt);
    chk(cnt == 1, "R9", "removal event", cnt, 1);
    chk(!card_present && card_misinserted, "R8", "crooked", {card_present, card_misinserted}, 2'b01);
    card_cd1_n = 1'b1;
    count_changes(8, cnt);
    chk(cnt == 0, "R9", "no event crooked to empty", cnt, 0);
    chk(!card_present && !card_misinserted, "R8", "empty", {card_present, card_misinserted}, 2'b00);

    // R11 reject with no card
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_lanes = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_reject && !req_accept, "R11", "reject pulse", {req_reject, req_accept}, 2'b10);
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (req_reject || req_accept || busy || !card_we_n || !card_oe_n) cnt++;
    end
    chk(cnt == 0, "R11", "nothing after reject", cnt, 0);

    card_cd1_n = 1'b0; card_cd2_n = 1'b0;
    count_changes(8, cnt);
    chk(cnt == 1, "R9", "reinsert event", cnt, 1);
    chk(card_present, "R8", "seated again", 32'(card_present), 1);

    // R10 battery codes
    for (int b = 0; b < 4; b++) begin
      logic [1:0] exp_b;
      {card_bvd2, card_bvd1} = 2'(b);
      exp_b = (b == 3) ? 2'b00 : (b == 1) ? 2'b01 : 2'b10;
      repeat (5) @(negedge clk);
      chk(batt_state == exp_b, "R10", "battery code", batt_state, exp_b);
    end

    report();
  end

endmodule